// File: doc/BRIEF.md
# Frequency-Comparing PWM Speed Regulator

This block closes the speed loop of a Hall-commutated three-phase motor drive. It watches two pulse trains: an external reference train whose rate sets the wanted speed, and a feedback train made from every transition of the Hall parity signal, which toggles once per electrical step. A small phase/frequency comparator state machine decides whether the reference is running ahead of or behind the feedback. A duty stepper then nudges a PWM duty value by one count per update interval in the matching direction. With 48 electrical steps per revolution, a 5 kHz reference asks for 6250 RPM.

The comparator has three states. `CMP_LEVEL` is the balanced state. `CMP_AHEAD` means the reference is faster and raises `faster`. `CMP_BEHIND` means the reference is slower and raises `slower`. The transitions are as follows. T_LEAD goes from LEVEL to AHEAD on a reference event that has no feedback event in the same cycle. T_LAG goes from LEVEL to BEHIND on a feedback event that has no reference event. T_CATCH goes from AHEAD back to LEVEL on a lone feedback event. T_RECOVER goes from BEHIND back to LEVEL on a lone reference event. Every other case is HOLD, which keeps the current state. The PWM carrier has 2^DUTY_BITS slots of PRESCALE clocks each. With DUTY_BITS=8 and PRESCALE=2 at 51.2 MHz, the carrier runs at 100 kHz. The duty is 0 after reset, so the motor is idle until reference pulses arrive.

Top module: `pwm_speed_regulator`

## Requirements
- R1: While reset is asserted, `duty` is 0, `pwm_out` is low, and both `faster` and `slower` are low.
- R2: A reference event is a rising edge of `ref_in` only; a falling edge has no effect. A feedback event is any edge of `hall_parity`, rising or falling.
- R3: The comparator follows T_LEAD, T_LAG, T_CATCH and T_RECOVER as named above. A reference event and a feedback event in the same cycle cause no state change. `faster` and `slower` are never high together.
- R4: While `faster` is high, `duty` rises by exactly 1 at each interval end. It saturates at 2^DUTY_BITS (full on) and never wraps.
- R5: While `slower` is high, `duty` falls by exactly 1 at each interval end, down to a floor of 1. Once non-zero, `duty` never returns to 0. A `duty` of 0 is left unchanged by `slower`.
- R6: When neither flag is high, `duty` holds its value.
- R7: In each carrier period, `pwm_out` is high for the first `duty`×PRESCALE clocks and low for the rest. A `duty` of 0 keeps the output always low; a `duty` of 2^DUTY_BITS keeps it always high.
- R8: `duty` changes only on the last clock of a carrier period. The new value is therefore first seen at the start of the next period, and no pulse is cut short.
- R9: An update interval is exactly UPDATE_PERIODS carrier periods. Consecutive duty steps are UPDATE_PERIODS×2^DUTY_BITS×PRESCALE clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference pulse train; its rate sets the wanted speed |
| hall_parity | input | 1 | Hall parity signal; toggles once per electrical step |
| pwm_out | output | 1 | PWM drive signal |
| duty | output | DUTY_BITS+1 | Current duty in 1/2^DUTY_BITS units (0 to 2^DUTY_BITS) |
| faster | output | 1 | Reference is ahead of the feedback |
| slower | output | 1 | Reference is behind the feedback |

## Verification
The bench uses a reduced carrier of 16 slots with an interval of two periods, so the duty range can be swept end to end. The comparator is tried with the following input patterns:
- lone reference edges, lone Hall rises and lone Hall falls, which tell each named transition apart;
- a reference fall, which must be ignored;
- a reference edge and a Hall edge arriving in the same cycle, which must leave the state unchanged.

Ramps in both directions check the step size and the interval spacing, and that each step lands on a period start. The ramps run into both saturation limits to separate clamping from wrapping. The pulse width and the number of pulses per window are measured at zero, minimum, full and intermediate duty.

// File: rtl/spd_reg_pkg.sv
package spd_reg_pkg;

    typedef enum logic [1:0] {
        CMP_LEVEL  = 2'b00,
        CMP_AHEAD  = 2'b01,
        CMP_BEHIND = 2'b10
    } cmp_state_t;

endpackage

// File: rtl/spd_edge_sync.sv
module spd_edge_sync #(
    parameter int SYNC_STAGES = 2,
    parameter bit BOTH_EDGES  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic event_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    generate
        if (BOTH_EDGES) begin : g_any_edge
            assign event_o = sync_q[SYNC_STAGES-1] ^ last_q;
        end else begin : g_rise_edge
            assign event_o = sync_q[SYNC_STAGES-1] & ~last_q;
        end
    endgenerate

endmodule

// File: rtl/spd_freq_cmp.sv
module spd_freq_cmp
    import spd_reg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_evt,
    input  logic fb_evt,
    output logic faster,
    output logic slower
);

    cmp_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMP_LEVEL;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMP_LEVEL: begin
                if (ref_evt && !fb_evt)      state_d = CMP_AHEAD;   // T_LEAD
                else if (fb_evt && !ref_evt) state_d = CMP_BEHIND;  // T_LAG
            end
            CMP_AHEAD: begin
                if (fb_evt && !ref_evt)      state_d = CMP_LEVEL;   // T_CATCH
            end
            CMP_BEHIND: begin
                if (ref_evt && !fb_evt)      state_d = CMP_LEVEL;   // T_RECOVER
            end
            default:                         state_d = CMP_LEVEL;
        endcase
    end

    // outputs
    always_comb begin
        faster = 1'b0;
        slower = 1'b0;
        unique case (state_q)
            CMP_LEVEL:  ;
            CMP_AHEAD:  faster = 1'b1;
            CMP_BEHIND: slower = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/spd_pwm_carrier.sv
module spd_pwm_carrier #(
    parameter int DUTY_BITS = 8,
    parameter int PRESCALE  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DUTY_BITS:0] duty,
    output logic               period_end,
    output logic               pwm_out
);

    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0]     pre_q;
    logic [DUTY_BITS-1:0] slot_q;
    logic                 slot_tick;

    assign slot_tick  = (pre_q == PRE_LAST);
    assign period_end = slot_tick && (slot_q == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            slot_q <= '0;
        end else begin
            pre_q <= slot_tick ? '0 : pre_q + 1'b1;
            if (slot_tick) slot_q <= slot_q + 1'b1;
        end
    end

    assign pwm_out = ({1'b0, slot_q} < duty);

endmodule

// File: rtl/spd_duty_stepper.sv
module spd_duty_stepper #(
    parameter int DUTY_BITS      = 8,
    parameter int UPDATE_PERIODS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               period_end,
    input  logic               faster,
    input  logic               slower,
    output logic               interval_done,
    output logic [DUTY_BITS:0] duty
);

    localparam int IC_W = (UPDATE_PERIODS > 1) ? $clog2(UPDATE_PERIODS) : 1;
    localparam logic [IC_W-1:0]    IC_LAST = IC_W'(UPDATE_PERIODS - 1);
    localparam logic [DUTY_BITS:0] FULL    = {1'b1, {DUTY_BITS{1'b0}}};
    localparam logic [DUTY_BITS:0] FLOOR   = {{DUTY_BITS{1'b0}}, 1'b1};

    logic [IC_W-1:0] ic_q;

    assign interval_done = period_end && (ic_q == IC_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ic_q <= '0;
            duty <= '0;
        end else begin
            if (period_end) ic_q <= (ic_q == IC_LAST) ? '0 : ic_q + 1'b1;
            if (interval_done) begin
                if (faster && duty != FULL)      duty <= duty + 1'b1;
                else if (slower && duty > FLOOR) duty <= duty - 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_speed_regulator.sv
module pwm_speed_regulator #(
    parameter int DUTY_BITS      = 8,
    parameter int PRESCALE       = 2,
    parameter int UPDATE_PERIODS = 4,
    parameter int SYNC_STAGES    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_in,
    input  logic               hall_parity,
    output logic               pwm_out,
    output logic [DUTY_BITS:0] duty,
    output logic               faster,
    output logic               slower
);

    logic ref_evt, fb_evt, period_end, interval_done;

    spd_edge_sync #(.SYNC_STAGES(SYNC_STAGES), .BOTH_EDGES(1'b0)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .din(ref_in), .event_o(ref_evt)
    );

    spd_edge_sync #(.SYNC_STAGES(SYNC_STAGES), .BOTH_EDGES(1'b1)) u_fb_sync (
        .clk(clk), .rst_n(rst_n), .din(hall_parity), .event_o(fb_evt)
    );

    spd_freq_cmp u_cmp (
        .clk(clk), .rst_n(rst_n), .ref_evt(ref_evt), .fb_evt(fb_evt),
        .faster(faster), .slower(slower)
    );

    spd_duty_stepper #(.DUTY_BITS(DUTY_BITS), .UPDATE_PERIODS(UPDATE_PERIODS)) u_step (
        .clk(clk), .rst_n(rst_n), .period_end(period_end),
        .faster(faster), .slower(slower),
        .interval_done(interval_done), .duty(duty)
    );

    spd_pwm_carrier #(.DUTY_BITS(DUTY_BITS), .PRESCALE(PRESCALE)) u_pwm (
        .clk(clk), .rst_n(rst_n), .duty(duty),
        .period_end(period_end), .pwm_out(pwm_out)
    );

endmodule

// File: rtl/spd_reg_checker.sv
module spd_reg_checker #(
    parameter int DUTY_BITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwm_out,
    input  logic [DUTY_BITS:0] duty,
    input  logic               faster,
    input  logic               slower,
    input  logic               period_end,
    input  logic               interval_done
);

    localparam logic [DUTY_BITS:0] FULL = {1'b1, {DUTY_BITS{1'b0}}};
    localparam logic [DUTY_BITS:0] ONE  = {{DUTY_BITS{1'b0}}, 1'b1};

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_state_r1: assert (duty == '0 && !faster && !slower && !pwm_out)
                else $error("reset state wrong");
        end
    end

    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(faster && slower));

    p_duty_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        duty <= FULL);

    p_up_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (interval_done && faster && duty != FULL) |=> duty == $past(duty) + ONE);

    p_down_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (interval_done && slower && duty > ONE) |=> duty == $past(duty) - ONE);

    p_no_zero_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (duty != '0) |=> (duty != '0));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!faster && !slower) |=> $stable(duty));

    p_pwm_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |-> !pwm_out);

    p_pwm_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == FULL) |-> pwm_out);

    p_change_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(duty));

    p_interval_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        interval_done |-> period_end);

endmodule

bind pwm_speed_regulator spd_reg_checker #(.DUTY_BITS(DUTY_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .duty(duty),
    .faster(faster), .slower(slower),
    .period_end(period_end), .interval_done(interval_done)
);

// File: tb/pwm_speed_regulator_tb.sv
module pwm_speed_regulator_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DB         = 4;
    localparam int PRE        = 2;
    localparam int UPD        = 2;
    localparam int FULL       = 1 << DB;
    localparam int PERIOD     = FULL * PRE;
    localparam int INTERVAL   = PERIOD * UPD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic hall_parity = 1'b0;
    logic pwm_out, faster, slower;
    logic [DB:0] duty;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_speed_regulator #(.DUTY_BITS(DB), .PRESCALE(PRE), .UPDATE_PERIODS(UPD)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .hall_parity(hall_parity),
        .pwm_out(pwm_out), .duty(duty), .faster(faster), .slower(slower)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic flags_check(input string tag, input int f, input int s);
        check(faster == f[0], {tag, " faster"}, int'(faster), f);
        check(slower == s[0], {tag, " slower"}, int'(slower), s);
    endtask

    task automatic ref_pulse();
        ref_in = 1'b1; tick(4);
        ref_in = 1'b0; tick(4);
    endtask

    task automatic hall_flip();
        hall_parity = ~hall_parity; tick(4);
    endtask

    task automatic measure_pwm(input int n, output int hi, output int rises);
        logic prev;
        hi = 0; rises = 0; prev = pwm_out;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (pwm_out) hi++;
            if (pwm_out && !prev) rises++;
            prev = pwm_out;
        end
    endtask

    // waits for the next duty change; returns clocks waited, pwm before/after
    task automatic wait_change(output int waited, output logic pb, output logic pa);
        logic [DB:0] d0;
        d0 = duty; waited = 0; pb = pwm_out; pa = pwm_out;
        while (duty == d0 && waited < 4 * INTERVAL) begin
            pb = pwm_out;
            tick(1);
            waited++;
        end
        pa = pwm_out;
    endtask

    initial begin
        int hi, rises, w, d;
        logic pb, pa;

        tick(3);
        check(duty == 0, "R1 duty in reset", int'(duty), 0);
        check(pwm_out == 0, "R1 pwm in reset", int'(pwm_out), 0);
        flags_check("R1 reset", 0, 0);
        rst_n = 1'b1;
        tick(2);

        // idle: no reference, duty stays zero, output off
        tick(200);
        check(duty == 0, "R6 idle duty", int'(duty), 0);
        measure_pwm(2 * PERIOD, hi, rises);
        check(hi == 0, "R7 zero duty pwm", hi, 0);

        // lone Hall rise: T_LAG; duty 0 untouched by slower
        hall_flip();
        flags_check("R3 T_LAG via hall rise (R2)", 0, 1);
        tick(3 * INTERVAL);
        check(duty == 0, "R5 slower at zero", int'(duty), 0);

        // lone reference edge: T_RECOVER
        ref_pulse();
        flags_check("R3 T_RECOVER", 0, 0);

        // Hall fall counts as feedback: T_LAG again
        hall_flip();
        flags_check("R2 hall fall is feedback", 0, 1);
        ref_pulse();
        flags_check("R3 back to level", 0, 0);

        // reference rise -> T_LEAD; Hall -> T_CATCH; reference fall ignored
        ref_in = 1'b1; tick(4);
        flags_check("R3 T_LEAD", 1, 0);
        hall_flip();
        flags_check("R3 T_CATCH", 0, 0);
        ref_in = 1'b0; tick(4);
        flags_check("R2 reference fall ignored", 0, 0);
        check(duty == 0, "R6 level keeps duty", int'(duty), 0);

        // simultaneous events: no change
        ref_in = 1'b1; hall_parity = ~hall_parity; tick(4);
        flags_check("R3 simultaneous events", 0, 0);
        ref_in = 1'b0; tick(4);

        // ramp up
        ref_pulse();
        flags_check("R3 T_LEAD for ramp", 1, 0);
        wait_change(w, pb, pa);
        check(duty == 1, "R4 first step from zero", int'(duty), 1);
        check(pa == 1 && pb == 0, "R8 step lands on period start", int'(pa), 1);
        for (int k = 0; k < 3; k++) begin
            d = int'(duty);
            wait_change(w, pb, pa);
            check(w == INTERVAL, "R9 step spacing up", w, INTERVAL);
            check(int'(duty) == d + 1, "R4 step up by one", int'(duty), d + 1);
            check(pa == 1 && pb == 0, "R8 rise at period start", int'(pa), 1);
        end
        tick(INTERVAL * (FULL + 2));
        check(int'(duty) == FULL, "R4 saturate at full", int'(duty), FULL);
        tick(2 * INTERVAL);
        check(int'(duty) == FULL, "R4 no wrap past full", int'(duty), FULL);
        measure_pwm(PERIOD, hi, rises);
        check(hi == PERIOD, "R7 full duty always high", hi, PERIOD);

        // two Hall edges: T_CATCH then T_LAG
        hall_flip();
        hall_flip();
        flags_check("R3 ahead to behind", 0, 1);
        wait_change(w, pb, pa);
        for (int k = 0; k < 3; k++) begin
            d = int'(duty);
            wait_change(w, pb, pa);
            check(w == INTERVAL, "R9 step spacing down", w, INTERVAL);
            check(int'(duty) == d - 1, "R5 step down by one", int'(duty), d - 1);
        end
        tick(INTERVAL * (FULL + 2));
        check(duty == 1, "R5 floor at one", int'(duty), 1);
        measure_pwm(PERIOD, hi, rises);
        check(hi == PRE, "R7 minimum pulse width", hi, PRE);

        // intermediate duty, then freeze
        ref_pulse();
        flags_check("R3 T_RECOVER from floor", 0, 0);
        ref_pulse();
        while (int'(duty) < 6) tick(1);
        hall_flip();
        flags_check("R3 T_CATCH at mid", 0, 0);
        d = int'(duty);
        tick(5 * INTERVAL);
        check(int'(duty) == d, "R6 hold at mid", int'(duty), d);
        measure_pwm(2 * PERIOD, hi, rises);
        check(hi == 2 * d * PRE, "R7 mid pulse width", hi, 2 * d * PRE);
        check(rises == 2, "R8 one pulse per period", rises, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule